// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a RAM array that two independent ports share, a left port and a right port. On every clock it checks whether both ports are enabled and pointing at the same word. When they are, it gives the word to the port that got there first and marks the other port as the loser. The loser gets an active-low busy flag. If both ports arrive in the same cycle, a fixed tie-break chooses the winner. The block also turns each port's request into a gated write strobe for the array. It raises a flag when a losing port reads. It produces a permit for mailbox side effects, such as raising or clearing a message interrupt, and withholds that permit from a busy port.

A strap input selects one of two roles. In the master role the block computes busy and drives it out through registers, so the busy pins change one cycle after the addresses or enables change. Write suppression in this role uses the decision made in the current cycle, so the loser's first write is already blocked. In the slave role the busy pins stay inactive, and busy is taken from an external master through two inputs. In that role busy only gates the writes and side effects.

Top module: `dp_contention_arbiter`

## Requirements
- R1: A synchronous active-high reset clears all ownership and port history. In the cycle after reset both busy outputs are high (inactive).
- R2: Busy is never driven low unless both enables are high and both addresses are equal. One clock after a cycle without such a match, both busy outputs are high.
- R3: When a match appears, a port wins if it held the same enable and address in the previous cycle and the other port did not. One clock later the other port's busy output is low. The winner keeps the word for as long as the match persists.
- R4: One clock after the addresses stop matching, or after either enable (including the winner's) goes low, the loser's busy output returns high.
- R5: When both ports reach a match in the same cycle, the left port wins when the tie parameter is 1, which is the default. The two busy outputs are never low together.
- R6: In the master role a write from the losing port gives no write strobe (`*_wr_en` = 0), including in the cycle the contention is decided. A write from the winner or from an uncontended port gives a strobe.
- R7: In the slave role both busy outputs stay high. A write from a port whose busy input is low gives no write strobe, and a write from a port whose busy input is high does.
- R8: The mailbox permit (`*_mbox_ok`) of a port is 1 only when that port is enabled and not busy. It is 0 for a busy port, whether busy is computed or taken from the inputs.
- R9: A read (enable 1, write 0) from a busy port is allowed but raises that port's read flag (`*_rd_flag` = 1). The flag is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | Role strap: 1 computes busy, 0 takes busy from the inputs |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left port write request (1 = write, 0 = read) |
| l_addr | input | ADDR_W | Left port word address |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right port write request (1 = write, 0 = read) |
| r_addr | input | ADDR_W | Right port word address |
| busy_in_l_n | input | 1 | External busy toward left port, active low (slave role) |
| busy_in_r_n | input | 1 | External busy toward right port, active low (slave role) |
| busy_out_l_n | output | 1 | Registered busy toward left port, active low |
| busy_out_r_n | output | 1 | Registered busy toward right port, active low |
| l_wr_en | output | 1 | Gated write strobe for the left port |
| r_wr_en | output | 1 | Gated write strobe for the right port |
| l_mbox_ok | output | 1 | Left port may cause mailbox side effects |
| r_mbox_ok | output | 1 | Right port may cause mailbox side effects |
| l_rd_flag | output | 1 | Left port is reading while busy |
| r_rd_flag | output | 1 | Right port is reading while busy |

## Verification
The bench targets the first-come decision in both directions. A design that chose the winner by a fixed side would hand the word to the newcomer. It also moves both addresses together while they still match, which catches a design that re-arbitrates on every address change and flips the winner. It drives a same-cycle tie, which exposes a design that grants both ports or neither, and it hits the exact decision cycle, where a design that gated writes from the registered busy would let the loser's first write through. In slave mode it sets contention on the ports while toggling the busy inputs, which catches a design that still drives busy out or ignores the external flag.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_L    = 2'd1,
        OWN_R    = 2'd2
    } owner_e;

    localparam int NPORT = 2;
    localparam int PL    = 0;
    localparam int PR    = 1;

    function automatic owner_e pick_first(input logic l_held, input logic r_held,
                                          input logic tie_left);
        if (l_held && !r_held)
            return OWN_L;
        else if (r_held && !l_held)
            return OWN_R;
        else
            return tie_left ? OWN_L : OWN_R;
    endfunction

endpackage

// File: rtl/dpa_port_hist.sv
module dpa_port_hist #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [ADDR_W-1:0] addr,
    output logic              held
);
    logic              ce_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            ce_q   <= ce;
            addr_q <= addr;
        end
    end

    assign held = ce && ce_q && (addr_q == addr);
endmodule

// File: rtl/dpa_owner_fsm.sv
module dpa_owner_fsm
    import dpa_pkg::*;
#(
    parameter bit TIE_LEFT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             match,
    input  logic [NPORT-1:0] held,
    output owner_e           owner_q,
    output owner_e           owner_nxt
);
    always_comb begin
        if (!match)
            owner_nxt = OWN_NONE;
        else if (owner_q != OWN_NONE)
            owner_nxt = owner_q;
        else
            owner_nxt = pick_first(held[PL], held[PR], TIE_LEFT);
    end

    always_ff @(posedge clk) begin
        if (rst)
            owner_q <= OWN_NONE;
        else
            owner_q <= owner_nxt;
    end
endmodule

// File: rtl/dpa_port_gate.sv
module dpa_port_gate (
    input  logic master_mode,
    input  logic ce,
    input  logic we,
    input  logic lose_now,
    input  logic busy_in_n,
    output logic wr_en,
    output logic mbox_ok,
    output logic rd_flag
);
    logic busy_eff;

    assign busy_eff = master_mode ? lose_now : !busy_in_n;
    assign wr_en    = ce && we && !busy_eff;
    assign mbox_ok  = ce && !busy_eff;
    assign rd_flag  = ce && !we && busy_eff;
endmodule

// File: rtl/dp_contention_arbiter.sv
module dp_contention_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter bit TIE_LEFT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_ce,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              busy_in_l_n,
    input  logic              busy_in_r_n,
    output logic              busy_out_l_n,
    output logic              busy_out_r_n,
    output logic              l_wr_en,
    output logic              r_wr_en,
    output logic              l_mbox_ok,
    output logic              r_mbox_ok,
    output logic              l_rd_flag,
    output logic              r_rd_flag
);
    logic [NPORT-1:0]  ce_v, we_v, held_v, lose_v, bin_v, wr_v, ok_v, rf_v;
    logic [ADDR_W-1:0] addr_v [NPORT];
    logic              match;
    owner_e            owner_q, owner_nxt;

    assign ce_v       = {r_ce, l_ce};
    assign we_v       = {r_we, l_we};
    assign bin_v      = {busy_in_r_n, busy_in_l_n};
    assign addr_v[PL] = l_addr;
    assign addr_v[PR] = r_addr;

    assign match = l_ce && r_ce && (l_addr == r_addr);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpa_port_hist #(.ADDR_W(ADDR_W)) u_hist (
            .clk  (clk),
            .rst  (rst),
            .ce   (ce_v[p]),
            .addr (addr_v[p]),
            .held (held_v[p])
        );

        dpa_port_gate u_gate (
            .master_mode (master_mode),
            .ce          (ce_v[p]),
            .we          (we_v[p]),
            .lose_now    (lose_v[p]),
            .busy_in_n   (bin_v[p]),
            .wr_en       (wr_v[p]),
            .mbox_ok     (ok_v[p]),
            .rd_flag     (rf_v[p])
        );
    end

    dpa_owner_fsm #(.TIE_LEFT(TIE_LEFT)) u_owner (
        .clk       (clk),
        .rst       (rst),
        .match     (match),
        .held      (held_v),
        .owner_q   (owner_q),
        .owner_nxt (owner_nxt)
    );

    assign lose_v[PL] = (owner_nxt == OWN_R);
    assign lose_v[PR] = (owner_nxt == OWN_L);

    assign busy_out_l_n = !(master_mode && (owner_q == OWN_R));
    assign busy_out_r_n = !(master_mode && (owner_q == OWN_L));

    assign l_wr_en   = wr_v[PL];
    assign r_wr_en   = wr_v[PR];
    assign l_mbox_ok = ok_v[PL];
    assign r_mbox_ok = ok_v[PR];
    assign l_rd_flag = rf_v[PL];
    assign r_rd_flag = rf_v[PR];
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              master_mode,
    input logic              l_ce,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_ce,
    input logic [ADDR_W-1:0] r_addr,
    input logic              busy_in_l_n,
    input logic              busy_in_r_n,
    input logic              busy_out_l_n,
    input logic              busy_out_r_n,
    input logic              l_wr_en,
    input logic              r_wr_en,
    input logic              l_mbox_ok,
    input logic              r_mbox_ok
);
    logic same;
    assign same = l_ce && r_ce && (l_addr == r_addr);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (busy_out_l_n && busy_out_r_n));

    p_no_match_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !same |=> (busy_out_l_n && busy_out_r_n));

    p_keep_left_r3: assert property (@(posedge clk) disable iff (rst)
        (master_mode && !busy_out_r_n && same) |=> (!master_mode || !busy_out_r_n));

    p_keep_right_r3: assert property (@(posedge clk) disable iff (rst)
        (master_mode && !busy_out_l_n && same) |=> (!master_mode || !busy_out_l_n));

    p_one_loser_r5: assert property (@(posedge clk) disable iff (rst)
        !(!busy_out_l_n && !busy_out_r_n));

    p_block_r_wr_r6: assert property (@(posedge clk) disable iff (rst)
        (master_mode && !busy_out_r_n && same) |-> !r_wr_en);

    p_block_l_wr_r6: assert property (@(posedge clk) disable iff (rst)
        (master_mode && !busy_out_l_n && same) |-> !l_wr_en);

    p_slave_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !master_mode |-> (busy_out_l_n && busy_out_r_n));

    p_slave_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (!master_mode && (!busy_in_l_n || !busy_in_r_n)) |->
            ((busy_in_l_n || !l_wr_en) && (busy_in_r_n || !r_wr_en)));

    p_mbox_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (master_mode && same && (!busy_out_l_n || !busy_out_r_n)) |->
            ((busy_out_l_n || !l_mbox_ok) && (busy_out_r_n || !r_mbox_ok)));
endmodule

bind dp_contention_arbiter dpa_checker #(.ADDR_W(ADDR_W)) u_dpa_checker (
    .clk          (clk),
    .rst          (rst),
    .master_mode  (master_mode),
    .l_ce         (l_ce),
    .l_addr       (l_addr),
    .r_ce         (r_ce),
    .r_addr       (r_addr),
    .busy_in_l_n  (busy_in_l_n),
    .busy_in_r_n  (busy_in_r_n),
    .busy_out_l_n (busy_out_l_n),
    .busy_out_r_n (busy_out_r_n),
    .l_wr_en      (l_wr_en),
    .r_wr_en      (r_wr_en),
    .l_mbox_ok    (l_mbox_ok),
    .r_mbox_ok    (r_mbox_ok)
);

// File: tb/test_dp_contention_arbiter.sv
module test_dp_contention_arbiter;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          master_mode = 1'b1;
    logic          l_ce = 1'b0, l_we = 1'b0, r_ce = 1'b0, r_we = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          busy_in_l_n = 1'b1, busy_in_r_n = 1'b1;
    logic          busy_out_l_n, busy_out_r_n, l_wr_en, r_wr_en;
    logic          l_mbox_ok, r_mbox_ok, l_rd_flag, r_rd_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dp_contention_arbiter #(.ADDR_W(AW), .TIE_LEFT(1'b1)) i_dp_contention_arbiter (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
        .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
        .busy_in_l_n(busy_in_l_n), .busy_in_r_n(busy_in_r_n),
        .busy_out_l_n(busy_out_l_n), .busy_out_r_n(busy_out_r_n),
        .l_wr_en(l_wr_en), .r_wr_en(r_wr_en),
        .l_mbox_ok(l_mbox_ok), .r_mbox_ok(r_mbox_ok),
        .l_rd_flag(l_rd_flag), .r_rd_flag(r_rd_flag)
    );

    typedef struct packed {
        logic [3:0]    rq;
        logic          m;
        logic          lce, lwe;
        logic [AW-1:0] la;
        logic          rce, rwe;
        logic [AW-1:0] ra;
        logic          bil, bir;
        logic          ewl, ewr, eokl, eokr, erfl, erfr, ebl, ebr;
    } vec_t;

    // rq  m  lce lwe la  rce rwe ra  bil bir | wl wr okl okr rfl rfr bl br
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{4'd2, 1'b1, 1'b1,1'b0,4'd3, 1'b1,1'b0,4'd5, 1'b1,1'b1, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1}, // R2 reads, no match
        '{4'd2, 1'b1, 1'b1,1'b1,4'd3, 1'b1,1'b1,4'd5, 1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1}, // R2 writes, no match
        '{4'd6, 1'b1, 1'b1,1'b0,4'd3, 1'b1,1'b1,4'd3, 1'b1,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0}, // R3 R6 R8 left first
        '{4'd9, 1'b1, 1'b1,1'b1,4'd3, 1'b1,1'b0,4'd3, 1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0}, // R9 loser read flagged
        '{4'd4, 1'b1, 1'b1,1'b0,4'd4, 1'b1,1'b0,4'd3, 1'b1,1'b1, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1}, // R4 mismatch release
        '{4'd3, 1'b1, 1'b1,1'b1,4'd3, 1'b1,1'b0,4'd3, 1'b1,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1}, // R3 right first
        '{4'd4, 1'b1, 1'b1,1'b1,4'd3, 1'b0,1'b0,4'd3, 1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1}, // R4 winner enable drop
        '{4'd2, 1'b1, 1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0, 1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1}, // R2 idle
        '{4'd5, 1'b1, 1'b1,1'b1,4'd7, 1'b1,1'b1,4'd7, 1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0}, // R5 tie to left
        '{4'd3, 1'b1, 1'b1,1'b0,4'd9, 1'b1,1'b0,4'd9, 1'b1,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0}, // R3 both move, owner kept
        '{4'd7, 1'b0, 1'b1,1'b1,4'd2, 1'b1,1'b1,4'd2, 1'b0,1'b1, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1}, // R7 slave left busy
        '{4'd7, 1'b0, 1'b1,1'b0,4'd2, 1'b1,1'b0,4'd2, 1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1}, // R7 R8 slave right busy
        '{4'd2, 1'b1, 1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0, 1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1}  // R2 idle master
    };

    task automatic check(input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        master_mode = v.m;
        l_ce = v.lce; l_we = v.lwe; l_addr = v.la;
        r_ce = v.rce; r_we = v.rwe; r_addr = v.ra;
        busy_in_l_n = v.bil; busy_in_r_n = v.bir;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        check("R1 busy_out_l_n after reset", busy_out_l_n, 1'b1);
        check("R1 busy_out_r_n after reset", busy_out_r_n, 1'b1);
        check("R1 l_wr_en idle", l_wr_en, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            #1;
            check($sformatf("R%0d v%0d l_wr_en", VEC[i].rq, i), l_wr_en, VEC[i].ewl);
            check($sformatf("R%0d v%0d r_wr_en", VEC[i].rq, i), r_wr_en, VEC[i].ewr);
            check($sformatf("R%0d v%0d l_mbox_ok", VEC[i].rq, i), l_mbox_ok, VEC[i].eokl);
            check($sformatf("R%0d v%0d r_mbox_ok", VEC[i].rq, i), r_mbox_ok, VEC[i].eokr);
            check($sformatf("R%0d v%0d l_rd_flag", VEC[i].rq, i), l_rd_flag, VEC[i].erfl);
            check($sformatf("R%0d v%0d r_rd_flag", VEC[i].rq, i), r_rd_flag, VEC[i].erfr);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d v%0d busy_out_l_n", VEC[i].rq, i), busy_out_l_n, VEC[i].ebl);
            check($sformatf("R%0d v%0d busy_out_r_n", VEC[i].rq, i), busy_out_r_n, VEC[i].ebr);
        end

        // R1: reset in the middle of a held contention clears ownership
        master_mode = 1'b1;
        l_ce = 1'b1; r_ce = 1'b1; l_we = 1'b0; r_we = 1'b0;
        l_addr = 4'd11; r_addr = 4'd11;
        @(posedge clk); @(negedge clk);
        check("R5 tie busy_out_r_n low", busy_out_r_n, 1'b0);
        check("R5 tie busy_out_l_n high", busy_out_l_n, 1'b1);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 mid-run reset busy_out_r_n", busy_out_r_n, 1'b1);
        check("R1 mid-run reset busy_out_l_n", busy_out_l_n, 1'b1);
        rst = 1'b0;
        // history was cleared: the persisting match is a fresh tie
        @(posedge clk); @(negedge clk);
        check("R5 post-reset tie busy_out_r_n", busy_out_r_n, 1'b0);
        r_we = 1'b1;
        #1;
        check("R6 loser write after reset", r_wr_en, 1'b0);
        l_ce = 1'b0; r_ce = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R4 release after enables drop", busy_out_r_n, 1'b1);

        finish_run();
    end
endmodule